// File: doc/BRIEF.md
# Configuration Port Unlock Sequencer

This block is the locked index/data configuration window of a peripheral controller. The host reaches it through byte-wide I/O writes and reads. It answers at two even port addresses, each paired with the odd address above it. The even address is the index port and the odd address is the data port. After reset the window is closed. Data reads return 0xFF and data writes change nothing. The window opens only when a four-byte key has been written to one of the two index ports. The last byte of that key depends on which of the two ports the key went to.

Once open, the window answers only on the port pair that was unlocked. A write to the index port latches a register number. Data-port accesses then reach that register. The register file holds two chip identification bytes, a logical-device number and a flash control byte. It also holds a flash base-address pair that is visible only while logical device 7 is selected. The flash control fields leave the block as plain outputs, and so do the base address and a combined flash-write permission. A dedicated exit write closes the window again.

Reads return their data one clock after the read strobe, together with a valid pulse.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the window is locked (`cfg_mode_o`=0). The flash control fields are 0, `flash_wr_allowed_o` is 0 and `flash_base_o` is 16'h0820.
- R2: Four consecutive index writes of 0x87, 0x01, 0x55, 0x55 to port 0x2E open the window. `cfg_mode_o` goes to 1 and `cfg_alt_o` goes to 0 at the clock edge that takes the fourth write.
- R3: At port 0x4E the key is 0x87, 0x01, 0x55, 0xAA, and it sets `cfg_alt_o` to 1. A fourth byte of 0xAA at 0x2E does not open the window, and neither does a fourth byte of 0x55 at 0x4E.
- R4: A wrong byte in the key, or a byte sent to the other index port than the first byte, sends the detector back to its start. If that wrong byte is 0x87, it counts as the first byte of a new key at the port it was written to.
- R5: While locked, every decoded read returns 0xFF and data-port writes change no register.
- R6: Register 0x20 reads 0x87 and register 0x21 reads 0x16.
- R7: Register 0x07 is a read/write logical-device number. When it equals 7, register 0x64 is the high byte and 0x65 the low byte of `flash_base_o`, both read/write. For any other device both read 0x00 and writes to them are ignored.
- R8: In register 0x24, bits 3:1 drive `flash_win_o[2:0]`, bit 4 drives `flash_host_wr_o` and bit 5 drives `flash_pin_alt_o`. Bits 0, 6 and 7 read 0.
- R9: `flash_wr_allowed_o` is 1 only when bit 4 of register 0x24 is set and at least one of bits 3:1 is set.
- R10: Writing 0x02 to register 0x02 closes the window and clears the index; writing any other value there does not. Register contents survive the close.
- R11: While open, only the unlocked pair answers, and reads on the other pair return 0xFF. An index-port read returns the latched index. Unimplemented registers read 0x00.
- R12: Read data appears one clock after the read strobe with `io_rvalid_o`. A read and a write in the same cycle on the data port return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | Host I/O address |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, valid with io_rvalid_o |
| io_rvalid_o | output | 1 | Read data valid, one cycle after a decoded read |
| cfg_mode_o | output | 1 | Window open |
| cfg_alt_o | output | 1 | Window opened on the alternate pair |
| flash_win_o | output | 3 | Flash decode window enables |
| flash_host_wr_o | output | 1 | Host write enable to flash |
| flash_pin_alt_o | output | 1 | Flash pin selection |
| flash_wr_allowed_o | output | 1 | Host flash writes effectively permitted |
| flash_base_o | output | 16 | Flash controller base port |

## Verification
A data-port read and a data-port write can land on the same register in the same cycle. The bench provokes this by raising both strobes in one cycle. It does so once on the device-number register and once on the exit register while the exit value is written. The read must carry the value held before the edge, and for the exit case it must carry the value read while the window was still open. A follow-up read then shows the written value, or 0xFF after the close.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_B0 = 8'h87;
  localparam logic [7:0] KEY_B1 = 8'h01;
  localparam logic [7:0] KEY_B2 = 8'h55;
  localparam logic [7:0] KEY_PRI = 8'h55;
  localparam logic [7:0] KEY_ALT = 8'hAA;

  localparam logic [7:0] IDX_EXIT = 8'h02;
  localparam logic [7:0] IDX_LDN = 8'h07;
  localparam logic [7:0] IDX_ID_HI = 8'h20;
  localparam logic [7:0] IDX_ID_LO = 8'h21;
  localparam logic [7:0] IDX_FCTL = 8'h24;
  localparam logic [7:0] IDX_BASE_HI = 8'h64;
  localparam logic [7:0] IDX_BASE_LO = 8'h65;
  localparam logic [7:0] EXIT_VAL = 8'h02;
  localparam logic [7:0] FLASH_LDN = 8'h07;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_GOT1,
    KS_GOT2,
    KS_GOT3
  } key_step_e;

  typedef struct packed {
    logic       pin_alt;
    logic       host_wr;
    logic [2:0] win;
  } fctl_t;
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PRI_PORT = 16'h002E,
  parameter logic [ADDR_W-1:0] ALT_PORT = 16'h004E
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [1:0]        hit_o,
  output logic              data_o
);
  localparam logic [ADDR_W-1:0] PORT_BASE [2] = '{PRI_PORT, ALT_PORT};

  for (genvar p = 0; p < 2; p++) begin : g_pair
    assign hit_o[p] = (addr_i[ADDR_W-1:1] == PORT_BASE[p][ADDR_W-1:1]);
  end

  assign data_o = addr_i[0];
endmodule

// File: rtl/cfg_key_det.sv
module cfg_key_det
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic       alt_i,
  input  logic [7:0] data_i,
  output logic       unlock_o,
  output logic       unlock_alt_o
);
  key_step_e step_q, step_d;
  logic      port_q, port_d;
  logic [7:0] exp_byte;
  logic      match;

  always_comb begin
    unique case (step_q)
      KS_IDLE: exp_byte = KEY_B0;
      KS_GOT1: exp_byte = KEY_B1;
      KS_GOT2: exp_byte = KEY_B2;
      default: exp_byte = alt_i ? KEY_ALT : KEY_PRI;
    endcase
  end

  // all key bytes must go to the port that took the first one
  assign match = (data_i == exp_byte) && ((step_q == KS_IDLE) || (alt_i == port_q));

  always_comb begin
    step_d = step_q;
    port_d = port_q;
    if (clr_i) begin
      step_d = KS_IDLE;
    end else if (wr_i) begin
      if (match) begin
        unique case (step_q)
          KS_IDLE: begin step_d = KS_GOT1; port_d = alt_i; end
          KS_GOT1: step_d = KS_GOT2;
          KS_GOT2: step_d = KS_GOT3;
          default: step_d = KS_IDLE;
        endcase
      end else if (data_i == KEY_B0) begin
        step_d = KS_GOT1;
        port_d = alt_i;
      end else begin
        step_d = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= KS_IDLE;
      port_q <= 1'b0;
    end else begin
      step_q <= step_d;
      port_q <= port_d;
    end
  end

  assign unlock_o     = wr_i && !clr_i && match && (step_q == KS_GOT3);
  assign unlock_alt_o = port_q;

  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && !match && data_i == KEY_B0) |=> (step_q == KS_GOT1));
  p_bad_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && !match && data_i != KEY_B0) |=> (step_q == KS_IDLE));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8716,
  parameter logic [15:0] BASE_RST = 16'h0820
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  idx_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output fctl_t       fctl_o,
  output logic [15:0] base_o
);
  localparam int unsigned BASE_BYTES = 2;

  logic [7:0] ldn_q;
  fctl_t      fctl_q;
  logic [7:0] base_b [BASE_BYTES];
  logic       flash_sel;

  assign flash_sel = (ldn_q == FLASH_LDN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q  <= '0;
      fctl_q <= '0;
    end else if (wr_i) begin
      if (idx_i == IDX_LDN)  ldn_q  <= wdata_i;
      if (idx_i == IDX_FCTL) fctl_q <= fctl_t'(wdata_i[5:1]);
    end
  end

  // byte b of the base lives at index IDX_BASE_LO - b
  for (genvar b = 0; b < BASE_BYTES; b++) begin : g_base
    localparam logic [7:0] MY_IDX = IDX_BASE_LO - 8'(b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 base_b[b] <= BASE_RST[b*8 +: 8];
      else if (wr_i && flash_sel && idx_i == MY_IDX) base_b[b] <= wdata_i;
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_LDN:     rdata_o = ldn_q;
      IDX_ID_HI:   rdata_o = CHIP_ID[15:8];
      IDX_ID_LO:   rdata_o = CHIP_ID[7:0];
      IDX_FCTL:    rdata_o = {2'b00, fctl_q, 1'b0};
      IDX_BASE_HI: rdata_o = flash_sel ? base_b[1] : 8'h00;
      IDX_BASE_LO: rdata_o = flash_sel ? base_b[0] : 8'h00;
      default:     rdata_o = 8'h00;
    endcase
  end

  assign fctl_o = fctl_q;
  assign base_o = {base_b[1], base_b[0]};

  p_base_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && flash_sel) |=> $stable(base_o));
  p_fctl_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && idx_i == IDX_FCTL) |=> $stable(fctl_o));
endmodule

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock
  import cfg_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PRI_PORT = 16'h002E,
  parameter logic [ADDR_W-1:0] ALT_PORT = 16'h004E,
  parameter logic [15:0] CHIP_ID  = 16'h8716,
  parameter logic [15:0] BASE_RST = 16'h0820
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              io_rvalid_o,
  output logic              cfg_mode_o,
  output logic              cfg_alt_o,
  output logic [2:0]        flash_win_o,
  output logic              flash_host_wr_o,
  output logic              flash_pin_alt_o,
  output logic              flash_wr_allowed_o,
  output logic [15:0]       flash_base_o
);
  logic [1:0] hit;
  logic       is_data, any_hit, on_active;
  logic       cfg_mode_q, act_alt_q;
  logic [7:0] idx_q;
  logic       key_wr, key_unlock, key_alt;
  logic       idx_wr, dat_wr, dat_rd, idx_rd, relock;
  logic [7:0] reg_rdata;
  logic [7:0] rdata_q;
  logic       rvalid_q;
  fctl_t      fctl;

  cfg_addr_dec #(
    .ADDR_W  (ADDR_W),
    .PRI_PORT(PRI_PORT),
    .ALT_PORT(ALT_PORT)
  ) u_dec (
    .addr_i(io_addr_i),
    .hit_o (hit),
    .data_o(is_data)
  );

  assign any_hit   = |hit;
  assign on_active = cfg_mode_q && hit[act_alt_q];
  assign key_wr    = io_wr_i && any_hit && !is_data && !cfg_mode_q;
  assign idx_wr    = io_wr_i && on_active && !is_data;
  assign dat_wr    = io_wr_i && on_active && is_data;
  assign dat_rd    = io_rd_i && on_active && is_data;
  assign idx_rd    = io_rd_i && on_active && !is_data;
  assign relock    = dat_wr && (idx_q == IDX_EXIT) && (io_wdata_i == EXIT_VAL);

  cfg_key_det u_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (cfg_mode_q),
    .wr_i        (key_wr),
    .alt_i       (hit[1]),
    .data_i      (io_wdata_i),
    .unlock_o    (key_unlock),
    .unlock_alt_o(key_alt)
  );

  cfg_regfile #(
    .CHIP_ID (CHIP_ID),
    .BASE_RST(BASE_RST)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (dat_wr),
    .idx_i  (idx_q),
    .wdata_i(io_wdata_i),
    .rdata_o(reg_rdata),
    .fctl_o (fctl),
    .base_o (flash_base_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_mode_q <= 1'b0;
      act_alt_q  <= 1'b0;
      idx_q      <= '0;
    end else begin
      if (key_unlock) begin
        cfg_mode_q <= 1'b1;
        act_alt_q  <= hit[1];
      end else if (relock) begin
        cfg_mode_q <= 1'b0;
      end
      if (relock)      idx_q <= '0;
      else if (idx_wr) idx_q <= io_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= 8'hFF;
    end else begin
      rvalid_q <= io_rd_i && any_hit;
      if (dat_rd)      rdata_q <= reg_rdata;
      else if (idx_rd) rdata_q <= idx_q;
      else             rdata_q <= 8'hFF;
    end
  end

  assign io_rdata_o         = rdata_q;
  assign io_rvalid_o        = rvalid_q;
  assign cfg_mode_o         = cfg_mode_q;
  assign cfg_alt_o          = act_alt_q;
  assign flash_win_o        = fctl.win;
  assign flash_host_wr_o    = fctl.host_wr;
  assign flash_pin_alt_o    = fctl.pin_alt;
  assign flash_wr_allowed_o = fctl.host_wr && (|fctl.win);

  p_unlock_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_q) |-> $past(key_unlock));
  p_key_tail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_q) |-> ($past(io_wr_i) && $past(io_wdata_i) == (act_alt_q ? 8'hAA : 8'h55)));
  p_locked_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !cfg_mode_q) |=> (io_rdata_o == 8'hFF));
  p_id_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_rd && idx_q == IDX_ID_HI) |=> (io_rdata_o == CHIP_ID[15:8]));
  p_relock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock |=> (!cfg_mode_q && idx_q == 8'h00));
  p_rvalid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && any_hit) |=> io_rvalid_o);
endmodule

// File: tb/cfg_port_unlock_tb_top.sv
module cfg_port_unlock_tb_top;
  localparam logic [15:0] P_IDX = 16'h002E, P_DAT = 16'h002F;
  localparam logic [15:0] A_IDX = 16'h004E, A_DAT = 16'h004F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, mode, alt, host_wr, pin_alt, wr_ok;
  logic [2:0]  win;
  logic [15:0] base;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  cfg_port_unlock dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .io_rvalid_o(rvalid),
    .cfg_mode_o(mode), .cfg_alt_o(alt), .flash_win_o(win),
    .flash_host_wr_o(host_wr), .flash_pin_alt_o(pin_alt),
    .flash_wr_allowed_o(wr_ok), .flash_base_o(base)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %04h expected %04h", tag, act, exp);
    end
  endtask

  task automatic wr_io(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_io(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rdwr_io(input logic [15:0] a, input logic [7:0] d, input logic [7:0] exp,
                         input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; wdata = d; rd = 1'b1; wr = 1'b1;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic key(input logic [15:0] a, input logic [7:0] last);
    wr_io(a, 8'h87); wr_io(a, 8'h01); wr_io(a, 8'h55); wr_io(a, last);
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr_io(P_IDX, idx); wr_io(P_DAT, d);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected rvalid", 16'(rdata), 16'hxxxx);
      end else begin
        check(tag_q.pop_front(), 16'(rdata), 16'(exp_q.pop_front()));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", 16'(mode), 16'h0);
    check("R1 base", base, 16'h0820);
    check("R1 fctl", {11'b0, pin_alt, host_wr, win}, 16'h0);
    check("R1 wr_allowed", 16'(wr_ok), 16'h0);
    rd_io(P_DAT, 8'hFF, "R5 locked read");
    wr_io(P_DAT, 8'h3E);
    check("R5 locked write fctl", {11'b0, pin_alt, host_wr, win}, 16'h0);

    // R3 wrong tail per port
    key(P_IDX, 8'hAA);
    check("R3 AA at primary", 16'(mode), 16'h0);
    key(A_IDX, 8'h55);
    check("R3 55 at alternate", 16'(mode), 16'h0);
    // R4 wrong middle byte
    wr_io(P_IDX, 8'h87); wr_io(P_IDX, 8'h02); wr_io(P_IDX, 8'h55); wr_io(P_IDX, 8'h55);
    check("R4 wrong byte", 16'(mode), 16'h0);
    // R4 port switch mid key
    wr_io(P_IDX, 8'h87); wr_io(A_IDX, 8'h01); wr_io(P_IDX, 8'h55); wr_io(P_IDX, 8'h55);
    check("R4 port switch", 16'(mode), 16'h0);
    // R4 0x87 restarts, then R2 unlock
    wr_io(P_IDX, 8'h87); wr_io(P_IDX, 8'h01); wr_io(P_IDX, 8'h87);
    wr_io(P_IDX, 8'h01); wr_io(P_IDX, 8'h55);
    check("R4 not yet open", 16'(mode), 16'h0);
    wr_io(P_IDX, 8'h55);
    check("R2 mode open", 16'(mode), 16'h1);
    check("R2 primary pair", 16'(alt), 16'h0);

    // R11 index read, R6 chip ID
    rd_io(P_IDX, 8'h00, "R11 index read");
    wr_io(P_IDX, 8'h20); rd_io(P_DAT, 8'h87, "R6 id hi");
    wr_io(P_IDX, 8'h21); rd_io(P_DAT, 8'h16, "R6 id lo");
    wr_io(P_IDX, 8'h30); rd_io(P_DAT, 8'h00, "R11 unimplemented");

    // R7 device select and base
    reg_wr(8'h07, 8'h07);
    rd_io(P_DAT, 8'h07, "R7 ldn readback");
    reg_wr(8'h64, 8'h12); reg_wr(8'h65, 8'h34);
    check("R7 base out", base, 16'h1234);
    rd_io(P_DAT, 8'h34, "R7 base lo read");
    reg_wr(8'h07, 8'h03);
    wr_io(P_IDX, 8'h64); rd_io(P_DAT, 8'h00, "R7 other ldn read");
    wr_io(P_DAT, 8'hEE);
    check("R7 other ldn write ignored", base, 16'h1234);
    reg_wr(8'h07, 8'h07);
    wr_io(P_IDX, 8'h64); rd_io(P_DAT, 8'h12, "R7 base hi read");

    // R8 / R9 flash control
    reg_wr(8'h24, 8'hFF);
    rd_io(P_DAT, 8'h3E, "R8 fctl readback");
    check("R8 fields", {11'b0, pin_alt, host_wr, win}, 16'h1F);
    check("R9 all set", 16'(wr_ok), 16'h1);
    wr_io(P_DAT, 8'h10);
    check("R9 no window", 16'(wr_ok), 16'h0);
    wr_io(P_DAT, 8'h04);
    check("R9 no host wr", 16'(wr_ok), 16'h0);
    check("R8 window bit", 16'(win), 16'h2);
    wr_io(P_DAT, 8'h14);
    check("R9 one window", 16'(wr_ok), 16'h1);

    // R11 other pair ignored
    rd_io(A_DAT, 8'hFF, "R11 other pair read");
    wr_io(A_IDX, 8'h20);
    rd_io(P_IDX, 8'h24, "R11 other pair index ignored");

    // R12 simultaneous read and write
    wr_io(P_IDX, 8'h07);
    rdwr_io(P_DAT, 8'h05, 8'h07, "R12 read old value");
    rd_io(P_DAT, 8'h05, "R12 write landed");
    reg_wr(8'h07, 8'h07);

    // R10 relock
    reg_wr(8'h02, 8'h01);
    check("R10 other value keeps open", 16'(mode), 16'h1);
    rdwr_io(P_DAT, 8'h02, 8'h00, "R12 read during exit");
    check("R10 closed", 16'(mode), 16'h0);
    rd_io(P_DAT, 8'hFF, "R10 closed read");
    check("R10 base kept", base, 16'h1234);
    check("R10 fctl kept", {11'b0, pin_alt, host_wr, win}, 16'h0A);
    wr_io(P_DAT, 8'h00);
    check("R5 locked write ignored", {11'b0, pin_alt, host_wr, win}, 16'h0A);

    // R3 alternate pair
    key(A_IDX, 8'hAA);
    check("R3 alt open", 16'(mode), 16'h1);
    check("R3 alt flag", 16'(alt), 16'h1);
    rd_io(A_IDX, 8'h00, "R10 index cleared");
    wr_io(A_IDX, 8'h21); rd_io(A_DAT, 8'h16, "R6 id lo alt");
    rd_io(P_DAT, 8'hFF, "R11 primary closed");
    wr_io(A_IDX, 8'h02); wr_io(A_DAT, 8'h02);
    check("R10 alt closed", 16'(mode), 16'h0);

    repeat (3) @(negedge clk);
    check("R12 pending reads", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule